// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-clock static RAM. It has registered inputs, a pipelined read path and an internal four-word burst address generator. Every address, data and control input is captured on the rising clock edge. The captured operation is carried out on the following edge. A read word therefore reaches the output register two edges after its address was presented.

A burst opens when either of two address strobes is raised while the part is selected. The processor strobe always opens with a read. The controller strobe may open with a write. After that, the two low address bits are stepped by an internal 2-bit counter, which advances only when the advance input is high. The order is linear (count added modulo 4) or interleaved (count XORed in), chosen each cycle by a mode input.

Writes are lane-granular. A global-write input forces every lane to be written. Otherwise a lane is written when both the byte-write enable and that lane's bit are high. The read path reports through an output-enable-gated data bus with a valid flag, which stands in for a tristate driver.

Top module: `burst_sram`

## Requirements
- R1: After reset, and before any access, `rdValid` is 0 and `rdData` is all zeros.
- R2: A read operation presented before clock edge k puts the addressed word on `rdData` with `rdValid` high after edge k+1.
- R3: The controller strobe (`ctrlStrobe`) with all three selects active loads `addr` as the burst start, whatever `advance` is. In that same operation it writes the word if the write controls ask for a write, and otherwise reads it.
- R4: The processor strobe (`procStrobe`) with all selects active and `ctrlStrobe` low loads `addr` and always reads; the write controls are ignored in that cycle.
- R5: With `interleave` = 0, continuing access n (0..3) of a burst uses low address bits (start + n) mod 4; the upper address bits stay those of the start address.
- R6: With `interleave` = 1, continuing access n uses low address bits start XOR n.
- R7: In a continuing cycle (no strobe) the burst count increments only when `advance` is 1; with `advance` = 0 the same address is accessed again.
- R8: `globalWr` = 1 writes both 9-bit lanes (lane 0 is bits 8:0, lane 1 is bits 17:9), regardless of `byteWrEn` and `laneWr`.
- R9: With `globalWr` = 0, lane i is written only if `byteWrEn` = 1 and `laneWr[i]` = 1; lanes not written keep their contents. If no lane is enabled, the cycle is a read.
- R10: The part is selected only when `selA` = 1, `selB` = 1 and `selN` = 0. `ctrlStrobe` while not selected ends the burst: `rdValid` is 0 two edges later, and later continuing cycles produce no output until a new burst is loaded.
- R11: `procStrobe` while not selected is ignored: an open burst continues as in a plain continuing cycle.
- R12: While `outEn` = 0, `rdValid` is 0 and `rdData` is all zeros; the effect is immediate, with no clock edge needed.
- R13: A write cycle produces no read output: `rdValid` is 0 after the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selA | input | 1 | Chip select, active high |
| selB | input | 1 | Chip select, active high |
| selN | input | 1 | Chip select, active low |
| procStrobe | input | 1 | Burst start, read-only, ignored while deselected |
| ctrlStrobe | input | 1 | Burst start with optional write; deselects when not selected |
| advance | input | 1 | Step the burst counter in continuing cycles |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| globalWr | input | 1 | Write all lanes |
| byteWrEn | input | 1 | Enable per-lane writes |
| laneWr | input | LANES | Per-lane write selects |
| addr | input | ADDR_W | Burst start address |
| wrData | input | LANES*LANE_W | Write data |
| outEn | input | 1 | Output enable for the read bus |
| rdData | output | LANES*LANE_W | Read data, zero when not valid |
| rdValid | output | 1 | Read bus carries valid data |

## Verification
The assertions relate strobes seen at one edge to `rdValid` two edges later. They assume that reset is not applied in between and that every input is a known value at each rising edge. The bench drives all inputs just after the falling edge, keeps them free of X from time zero, and holds reset only at the start, so each strobe has a full two-edge window. Output enable is judged at the sampling edge itself. The bench therefore drops it only in cycles where it also expects no valid data.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Strobes from the control unit to the datapath, one cycle's operation.
  typedef struct packed {
    logic readNow;
    logic writeNow;
  } accStrobe_t;

  localparam int unsigned CNT_W = 2;

endpackage

// File: rtl/burst_sram_order.sv
module burst_sram_order
  import burst_sram_pkg::*;
(
  input  logic [CNT_W-1:0] startLow,
  input  logic [CNT_W-1:0] count,
  input  logic             interleave,
  output logic [CNT_W-1:0] low
);

  logic [CNT_W-1:0] linLow;
  logic [CNT_W-1:0] xorLow;

  // Linear order wraps inside the four-word block; interleaved flips bits.
  assign linLow = startLow + count;
  assign xorLow = startLow ^ count;
  assign low    = interleave ? xorLow : linLow;

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selA,
  input  logic              selB,
  input  logic              selN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              advance,
  input  logic              interleave,
  input  logic              globalWr,
  input  logic              byteWrEn,
  input  logic [LANES-1:0]  laneWr,
  input  logic [ADDR_W-1:0] addr,
  output accStrobe_t        strobe,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  wrMask
);

  localparam int unsigned HI_W = ADDR_W - CNT_W;

  // Input register stage
  logic [ADDR_W-1:0] rAddr;
  logic              rSelA, rSelB, rSelN;
  logic              rProc, rCtrl, rAdv, rMode;
  logic              rGw, rBwe;
  logic [LANES-1:0]  rLane;

  // Burst state
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  burstCnt;
  logic              burstActive;

  // Decoded operation of the registered cycle
  logic              selected;
  logic              loadProc, loadCtrl, loadNow, deselNow, contNow;
  logic              accessNow, writeNow;
  logic [CNT_W-1:0]  nextCnt;
  logic [ADDR_W-1:0] baseNow;
  logic [CNT_W-1:0]  lowBits;
  logic [HI_W-1:0]   highBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rAddr <= '0;
      rSelA <= 1'b0;
      rSelB <= 1'b0;
      rSelN <= 1'b1;
      rProc <= 1'b0;
      rCtrl <= 1'b0;
      rAdv  <= 1'b0;
      rMode <= 1'b0;
      rGw   <= 1'b0;
      rBwe  <= 1'b0;
      rLane <= '0;
    end else begin
      rAddr <= addr;
      rSelA <= selA;
      rSelB <= selB;
      rSelN <= selN;
      rProc <= procStrobe;
      rCtrl <= ctrlStrobe;
      rAdv  <= advance;
      rMode <= interleave;
      rGw   <= globalWr;
      rBwe  <= byteWrEn;
      rLane <= laneWr;
    end
  end

  always_comb begin
    selected = rSelA & rSelB & ~rSelN;
    loadCtrl = rCtrl & selected;
    loadProc = rProc & selected & ~rCtrl;
    loadNow  = loadCtrl | loadProc;
    deselNow = rCtrl & ~selected;
    contNow  = ~rCtrl & ~loadProc & burstActive;

    if (rGw)       wrMask = '1;
    else if (rBwe) wrMask = rLane;
    else           wrMask = '0;

    accessNow = loadNow | contNow;
    writeNow  = accessNow & ~loadProc & (|wrMask);

    if (loadNow)              nextCnt = '0;
    else if (contNow && rAdv) nextCnt = burstCnt + 1'b1;
    else                      nextCnt = burstCnt;

    baseNow  = loadNow ? rAddr : baseAddr;
    highBits = baseNow[ADDR_W-1:CNT_W];
  end

  burst_sram_order i_order (
    .startLow   (baseNow[CNT_W-1:0]),
    .count      (nextCnt),
    .interleave (rMode),
    .low        (lowBits)
  );

  assign accAddr         = {highBits, lowBits};
  assign strobe.writeNow = writeNow;
  assign strobe.readNow  = accessNow & ~writeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr    <= '0;
      burstCnt    <= '0;
      burstActive <= 1'b0;
    end else begin
      if (loadNow) baseAddr <= rAddr;
      burstCnt <= nextCnt;
      if (loadNow)       burstActive <= 1'b1;
      else if (deselNow) burstActive <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  accStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         accAddr,
  input  logic [LANES-1:0]          wrMask,
  input  logic [LANES*LANE_W-1:0]   wrData,
  input  logic                      outEn,
  output logic [LANES*LANE_W-1:0]   rdData,
  output logic                      rdValid
);

  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rWrData;
  logic [DATA_W-1:0] outReg;
  logic              validReg;

  // Write data lines up with its control in the input stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rWrData <= '0;
    else       rWrData <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.writeNow) begin
      for (int lane = 0; lane < LANES; lane++) begin
        if (wrMask[lane])
          mem[accAddr][lane*LANE_W +: LANE_W] <= rWrData[lane*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      validReg <= 1'b0;
    end else begin
      if (strobe.readNow) outReg <= mem[accAddr];
      validReg <= strobe.readNow;
    end
  end

  assign rdValid = validReg & outEn;
  assign rdData  = rdValid ? outReg : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    selA,
  input  logic                    selB,
  input  logic                    selN,
  input  logic                    procStrobe,
  input  logic                    ctrlStrobe,
  input  logic                    advance,
  input  logic                    interleave,
  input  logic                    globalWr,
  input  logic                    byteWrEn,
  input  logic [LANES-1:0]        laneWr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEn,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  accStrobe_t        strobe;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  wrMask;

  burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selA       (selA),
    .selB       (selB),
    .selN       (selN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .advance    (advance),
    .interleave (interleave),
    .globalWr   (globalWr),
    .byteWrEn   (byteWrEn),
    .laneWr     (laneWr),
    .addr       (addr),
    .strobe     (strobe),
    .accAddr    (accAddr),
    .wrMask     (wrMask)
  );

  burst_sram_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .accAddr (accAddr),
    .wrMask  (wrMask),
    .wrData  (wrData),
    .outEn   (outEn),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             selA,
  input logic             selB,
  input logic             selN,
  input logic             procStrobe,
  input logic             ctrlStrobe,
  input logic             globalWr,
  input logic             byteWrEn,
  input logic [LANES-1:0] laneWr,
  input logic             outEn,
  input logic             rdValid
);

  logic sel;
  logic wantsWrite;
  assign sel        = selA & selB & ~selN;
  assign wantsWrite = globalWr | (byteWrEn & (|laneWr));

  AST_PROC_READ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && sel && !ctrlStrobe) |-> ##2 (rdValid || !outEn)); // R4

  AST_CTRL_READ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe && sel && !wantsWrite) |-> ##2 (rdValid || !outEn)); // R3

  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe && sel && wantsWrite) |-> ##2 !rdValid); // R13

  AST_DESELECT_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe && !sel) |-> ##2 !rdValid); // R10

endmodule

bind burst_sram burst_sram_checker #(.LANES(LANES)) i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .selA       (selA),
  .selB       (selB),
  .selN       (selN),
  .procStrobe (procStrobe),
  .ctrlStrobe (ctrlStrobe),
  .globalWr   (globalWr),
  .byteWrEn   (byteWrEn),
  .laneWr     (laneWr),
  .outEn      (outEn),
  .rdValid    (rdValid)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selA = 1'b0, selB = 1'b0, selN = 1'b1;
  logic        procStrobe = 1'b0, ctrlStrobe = 1'b0, advance = 1'b0, interleave = 1'b0;
  logic        globalWr = 1'b0, byteWrEn = 1'b0;
  logic [1:0]  laneWr = 2'b00;
  logic [5:0]  addr = '0;
  logic [17:0] wrData = '0;
  logic        outEn = 1'b1;
  logic [17:0] rdData;
  logic        rdValid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_sram i_burst_sram (
    .clk(clk), .rstN(rstN), .selA(selA), .selB(selB), .selN(selN),
    .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe), .advance(advance),
    .interleave(interleave), .globalWr(globalWr), .byteWrEn(byteWrEn),
    .laneWr(laneWr), .addr(addr), .wrData(wrData), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct {
    logic        expValid;
    logic [17:0] expData;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [17:0] model [64];
  logic [5:0]  mBase = '0;
  logic [1:0]  mCnt = '0;
  logic        mActive = 1'b0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Driver: one operation per cycle, expected outcome pushed to the scoreboard.
  task automatic issue(input logic a, input logic b, input logic n,
                       input logic p, input logic c, input logic adv,
                       input logic mode, input logic gw, input logic bwe,
                       input logic [1:0] lane, input logic [5:0] ad,
                       input logic [17:0] d, input logic oe, input string tag);
    item_t it;
    logic sel, ldP, ldC, acc, wr;
    logic [1:0] mask, low;
    logic [5:0] ea;
    @(negedge clk);
    selA = a; selB = b; selN = n; procStrobe = p; ctrlStrobe = c;
    advance = adv; interleave = mode; globalWr = gw; byteWrEn = bwe;
    laneWr = lane; addr = ad; wrData = d; outEn = oe;
    sel = a & b & ~n;
    ldC = c & sel;
    ldP = p & sel & ~c;
    mask = gw ? 2'b11 : (bwe ? lane : 2'b00);
    acc = 1'b0;
    if (ldC || ldP) begin
      mBase = ad; mCnt = 2'd0; mActive = 1'b1; acc = 1'b1;
    end else if (c && !sel) begin
      mActive = 1'b0;
    end else if (mActive) begin
      if (adv) mCnt = mCnt + 2'd1;
      acc = 1'b1;
    end
    wr  = acc && !ldP && (mask != 2'b00);
    low = mode ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    ea  = {mBase[5:2], low};
    it.tag = tag;
    it.expValid = 1'b0;
    it.expData = '0;
    if (wr) begin
      if (mask[0]) model[ea][8:0]  = d[8:0];
      if (mask[1]) model[ea][17:9] = d[17:9];
    end else if (acc) begin
      it.expValid = 1'b1;
      it.expData = model[ea];
    end
    sb.push_back(it);
  endtask

  task automatic rdP(input logic [5:0] ad, input logic mode, input string tag);
    issue(1, 1, 0, 1, 0, 0, mode, 0, 0, 2'b00, ad, '0, 1, tag);
  endtask

  task automatic step(input logic adv, input logic mode, input string tag);
    issue(1, 1, 0, 0, 0, adv, mode, 0, 0, 2'b00, '0, '0, 1, tag);
  endtask

  task automatic wrC(input logic [5:0] ad, input logic gw, input logic bwe,
                     input logic [1:0] lane, input logic [17:0] d, input string tag);
    issue(1, 1, 0, 0, 1, 0, 0, gw, bwe, lane, ad, d, 1, tag);
  endtask

  // Monitor: compares the output two cycles after each operation.
  initial begin
    item_t it;
    logic ev;
    logic [17:0] ed;
    forever begin
      @(negedge clk);
      #5;
      if (sb.size() >= 3) begin
        it = sb.pop_front();
        ev = outEn ? it.expValid : 1'b0;
        ed = ev ? it.expData : '0;
        if (!outEn) it.tag = {it.tag, "/R12"};
        checks++;
        if (rdValid !== ev || rdData !== ed) begin
          errors++;
          $display("FAIL %s: rdValid=%b rdData=%h expected rdValid=%b rdData=%h",
                   it.tag, rdValid, rdData, ev, ed);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #5;
    checks++;
    if (rdValid !== 1'b0 || rdData !== '0) begin
      errors++;
      $display("FAIL R1: rdValid=%b rdData=%h expected rdValid=0 rdData=0", rdValid, rdData);
    end

    // Fill every word with a known pattern by global writes (R8, R13).
    for (int i = 0; i < 64; i++)
      wrC(6'(i), 1, 0, 2'b00, {6'(i), 3'b101, 6'(i) ^ 6'h2a, 3'b010}, "R8/R13 fill");

    // Processor strobe reads; write controls ignored (R2, R4).
    rdP(6'd5, 0, "R2 single read");
    issue(1, 1, 0, 1, 0, 0, 0, 1, 1, 2'b11, 6'd6, 18'h3ffff, 1, "R4 write ignored");
    rdP(6'd6, 0, "R4 reread");

    // Linear and interleaved orders from the same start (R5, R6).
    rdP(6'd9, 0, "R5 start");
    step(1, 0, "R5 n1");
    step(1, 0, "R5 n2");
    step(1, 0, "R5 n3");
    step(1, 0, "R5 wrap");
    rdP(6'd9, 1, "R6 start");
    step(1, 1, "R6 n1");
    step(1, 1, "R6 n2");
    step(1, 1, "R6 n3");

    // Advance low keeps the address (R7).
    rdP(6'd14, 0, "R7 start");
    step(0, 0, "R7 hold");
    step(1, 0, "R7 step");
    step(0, 0, "R7 hold2");

    // Controller strobe loads and writes whatever advance is (R3).
    issue(1, 1, 0, 0, 1, 1, 0, 1, 0, 2'b00, 6'd20, 18'h2a5a5, 1, "R3 write");
    rdP(6'd20, 0, "R3 readback");
    issue(1, 1, 0, 0, 1, 1, 0, 0, 0, 2'b00, 6'd21, '0, 1, "R3 read load");
    step(1, 0, "R3 burst next");

    // Per-lane writes (R9) and global override (R8).
    wrC(6'd24, 0, 1, 2'b01, 18'h155aa, "R9 lane0");
    rdP(6'd24, 0, "R9 lane0 read");
    wrC(6'd24, 0, 1, 2'b10, 18'h0aa55, "R9 lane1");
    rdP(6'd24, 0, "R9 lane1 read");
    wrC(6'd24, 0, 0, 2'b11, 18'h3ffff, "R9 bwe low reads");
    rdP(6'd24, 0, "R9 unchanged");
    wrC(6'd25, 1, 0, 2'b00, 18'h12345, "R8 override");
    rdP(6'd25, 0, "R8 read");

    // Burst writes in continuing cycles.
    rdP(6'd28, 1, "R3 burst base");
    issue(1, 1, 0, 0, 0, 1, 1, 0, 1, 2'b11, '0, 18'h01111, 1, "R9 burst write");
    rdP(6'd29, 0, "R9 burst readback");

    // Deselect by each select (R10).
    rdP(6'd32, 0, "R10 start");
    issue(0, 1, 0, 0, 1, 0, 0, 0, 0, 2'b00, '0, '0, 1, "R10 selA low");
    step(1, 0, "R10 idle1");
    step(1, 0, "R10 idle2");
    rdP(6'd33, 0, "R10 restart");
    issue(1, 0, 0, 0, 1, 0, 0, 0, 0, 2'b00, '0, '0, 1, "R10 selB low");
    step(0, 0, "R10 idle3");
    rdP(6'd34, 0, "R10 restart2");
    issue(1, 1, 1, 0, 1, 0, 0, 0, 0, 2'b00, '0, '0, 1, "R10 selN high");
    step(1, 0, "R10 idle4");

    // Processor strobe while deselected is ignored (R11).
    rdP(6'd40, 0, "R11 start");
    issue(1, 0, 0, 1, 0, 1, 0, 0, 0, 2'b00, 6'd50, '0, 1, "R11 ignored");
    step(1, 0, "R11 continue");

    // Output enable gating (R12).
    rdP(6'd44, 0, "R12 read");
    step(1, 0, "R12 next");
    issue(1, 1, 0, 0, 0, 1, 0, 0, 0, 2'b00, '0, '0, 0, "R12 oe low");
    issue(1, 1, 0, 0, 0, 1, 0, 0, 0, 2'b00, '0, '0, 0, "R12 oe low2");
    step(0, 0, "R12 oe back");
    issue(1, 1, 0, 0, 1, 0, 0, 0, 0, 2'b00, '0, '0, 1, "flush");
    step(0, 0, "flush");
    step(0, 0, "flush");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule